// File: doc/BRIEF.md
# Eviction-Marked Prefetch Trigger

This block links instruction-cache blocks back to the fetch-target-buffer entries that predicted them, so that a block pushed out of the cache is prefetched again as soon as the predictor next points at it. Every cache slot keeps a back-pointer, which is the index of the predictor entry whose prediction caused the fill, and an occupied flag. Every predictor entry keeps one mark bit.

When the cache evicts an occupied slot, the mark bit of the entry named by that slot's back-pointer is set. When a later prediction reads a marked entry, the block raises a prefetch request for the predicted address in the same cycle. The mark is cleared once that request is accepted. A request that is refused leaves the mark set, so the next prediction through that entry tries again. The predictor's target logic and the cache data arrays sit outside this block.

Top module: `efp_trigger`

## Requirements
- R1: After reset, every mark bit is clear and every slot is empty, so no prediction raises `pf_valid` until an occupied slot has been evicted.
- R2: A fill (`fill_valid`) makes slot `fill_slot` occupied and stores `fill_entry` as its back-pointer.
- R3: An eviction of an occupied slot sets the mark bit of the entry stored in that slot's back-pointer. The new mark is visible to predictions from the following cycle on.
- R4: In a cycle with `pred_valid` high and the mark of `pred_entry` set, `pf_valid` is high and `pf_addr` equals `pred_addr` in that same cycle. In any other cycle, `pf_valid` is low.
- R5: A mark is cleared at the clock edge where `pf_valid` and `pf_ready` are both high. If `pf_ready` is low, the mark stays set and the next prediction of that entry raises the request again.
- R6: An eviction empties its slot. An eviction of an empty slot changes no mark, so a repeated eviction of the same slot has no effect.
- R7: When an eviction and a prediction target the same entry in the same cycle, the prediction sees the old mark value. The set takes effect at that edge and wins over a clear caused by an accepted request in the same cycle.
- R8: When a fill and an eviction name the same slot in the same cycle, the eviction uses the old back-pointer, and the slot is left occupied with the new one.
- R9: Marks are kept separately for each entry: setting or clearing one entry's mark leaves every other entry's mark unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | A cache slot is being filled |
| fill_slot | input | 6 | Slot being filled |
| fill_entry | input | 5 | Predictor entry that caused the fill |
| evict_valid | input | 1 | A cache slot is being evicted |
| evict_slot | input | 6 | Slot being evicted |
| pred_valid | input | 1 | The predictor hit an entry this cycle |
| pred_entry | input | 5 | Index of the predictor entry that hit |
| pred_addr | input | 32 | Block address predicted by that entry |
| pf_valid | output | 1 | Prefetch request |
| pf_addr | output | 32 | Address to prefetch |
| pf_ready | input | 1 | The prefetch request is accepted |

## Verification
The hardest situations to reach from the ports are collisions inside a single cycle. One is an eviction whose back-pointer names the very entry being predicted while that prediction's request is also accepted. The other is a fill and an eviction hitting the same slot at once. Directed sequences first load a known back-pointer and then fire each collision deliberately. A seeded random phase then draws slots and entries from narrow ranges, so that such collisions keep recurring, and it compares the outputs against a bench model every cycle.

// File: rtl/efp_pkg.sv
package efp_pkg;
    localparam int unsigned DEF_SLOTS   = 64;
    localparam int unsigned DEF_ENTRIES = 32;
    localparam int unsigned DEF_ADDR_W  = 32;
endpackage

// File: rtl/efp_slot_table.sv
module efp_slot_table #(
    parameter int unsigned NUM_SLOTS   = efp_pkg::DEF_SLOTS,
    parameter int unsigned NUM_ENTRIES = efp_pkg::DEF_ENTRIES,
    localparam int unsigned SLOT_W     = $clog2(NUM_SLOTS),
    localparam int unsigned ENTRY_W    = $clog2(NUM_ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fill_valid,
    input  logic [SLOT_W-1:0]  fill_slot,
    input  logic [ENTRY_W-1:0] fill_entry,
    input  logic               evict_valid,
    input  logic [SLOT_W-1:0]  evict_slot,
    output logic               mark_valid,
    output logic [ENTRY_W-1:0] mark_entry
);
    typedef struct packed {
        logic [NUM_SLOTS-1:0]              occ;
        logic [NUM_SLOTS-1:0][ENTRY_W-1:0] ptr;
    } slot_state_t;

    slot_state_t st_d, st_q;

    // Eviction first, then fill: a fill to the slot being evicted wins.
    always_comb begin
        st_d = st_q;
        if (evict_valid) begin
            st_d.occ[evict_slot] = 1'b0;
        end
        if (fill_valid) begin
            st_d.occ[fill_slot] = 1'b1;
            st_d.ptr[fill_slot] = fill_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // The back-pointer is read from registered state, so the old owner is marked.
    assign mark_valid = evict_valid && st_q.occ[evict_slot];
    assign mark_entry = st_q.ptr[evict_slot];

    AST_FILL_RECORDS: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> (st_q.occ[$past(fill_slot)] && st_q.ptr[$past(fill_slot)] == $past(fill_entry))); // R2

    AST_EVICT_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (evict_valid && !(fill_valid && fill_slot == evict_slot)) |=> !st_q.occ[$past(evict_slot)]); // R6
endmodule

// File: rtl/efp_mark_bits.sv
module efp_mark_bits #(
    parameter int unsigned NUM_ENTRIES = efp_pkg::DEF_ENTRIES,
    localparam int unsigned ENTRY_W    = $clog2(NUM_ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en,
    input  logic [ENTRY_W-1:0] set_idx,
    input  logic               clr_en,
    input  logic [ENTRY_W-1:0] rd_idx,
    output logic               rd_bit
);
    typedef struct packed {
        logic [NUM_ENTRIES-1:0] bits;
    } mark_state_t;

    mark_state_t mk_d, mk_q;

    // Per-entry next value: a set on the same edge overrides a clear.
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
        always_comb begin
            mk_d.bits[g] = mk_q.bits[g];
            if (clr_en && rd_idx == ENTRY_W'(g)) begin
                mk_d.bits[g] = 1'b0;
            end
            if (set_en && set_idx == ENTRY_W'(g)) begin
                mk_d.bits[g] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mk_q <= '0;
        end else begin
            mk_q <= mk_d;
        end
    end

    assign rd_bit = mk_q.bits[rd_idx];

    AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> mk_q.bits[$past(set_idx)]); // R3

    AST_CLEAR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !(set_en && set_idx == rd_idx)) |=> !mk_q.bits[$past(rd_idx)]); // R5

    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en && !clr_en) |=> $stable(mk_q.bits)); // R9
endmodule

// File: rtl/efp_trigger.sv
module efp_trigger #(
    parameter int unsigned NUM_SLOTS   = efp_pkg::DEF_SLOTS,
    parameter int unsigned NUM_ENTRIES = efp_pkg::DEF_ENTRIES,
    parameter int unsigned ADDR_W      = efp_pkg::DEF_ADDR_W,
    localparam int unsigned SLOT_W     = $clog2(NUM_SLOTS),
    localparam int unsigned ENTRY_W    = $clog2(NUM_ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fill_valid,
    input  logic [SLOT_W-1:0]  fill_slot,
    input  logic [ENTRY_W-1:0] fill_entry,
    input  logic               evict_valid,
    input  logic [SLOT_W-1:0]  evict_slot,
    input  logic               pred_valid,
    input  logic [ENTRY_W-1:0] pred_entry,
    input  logic [ADDR_W-1:0]  pred_addr,
    output logic               pf_valid,
    output logic [ADDR_W-1:0]  pf_addr,
    input  logic               pf_ready
);
    logic               mark_valid;
    logic [ENTRY_W-1:0] mark_entry;
    logic               hit_bit;

    efp_slot_table #(
        .NUM_SLOTS   (NUM_SLOTS),
        .NUM_ENTRIES (NUM_ENTRIES)
    ) slots_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .fill_valid  (fill_valid),
        .fill_slot   (fill_slot),
        .fill_entry  (fill_entry),
        .evict_valid (evict_valid),
        .evict_slot  (evict_slot),
        .mark_valid  (mark_valid),
        .mark_entry  (mark_entry)
    );

    efp_mark_bits #(
        .NUM_ENTRIES (NUM_ENTRIES)
    ) marks_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (mark_valid),
        .set_idx (mark_entry),
        .clr_en  (pf_valid && pf_ready),
        .rd_idx  (pred_entry),
        .rd_bit  (hit_bit)
    );

    assign pf_valid = pred_valid && hit_bit;
    assign pf_addr  = pred_addr;

    AST_ACCEPT_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && pf_ready && !(mark_valid && mark_entry == pred_entry))
        |=> !(pf_valid && pred_entry == $past(pred_entry))); // R5
endmodule

// File: tb/efp_trigger_tb.sv
module efp_trigger_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 64;
    localparam int NE = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fill_valid = 1'b0;
    logic [5:0]  fill_slot = '0;
    logic [4:0]  fill_entry = '0;
    logic        evict_valid = 1'b0;
    logic [5:0]  evict_slot = '0;
    logic        pred_valid = 1'b0;
    logic [4:0]  pred_entry = '0;
    logic [31:0] pred_addr = '0;
    logic        pf_valid;
    logic [31:0] pf_addr;
    logic        pf_ready = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    bit       m_occ [NS];
    bit [4:0] m_ptr [NS];
    bit       m_mark[NE];

    always #(CLK_PERIOD/2) clk = ~clk;

    efp_trigger dut_i (
        .clk(clk), .rst_n(rst_n),
        .fill_valid(fill_valid), .fill_slot(fill_slot), .fill_entry(fill_entry),
        .evict_valid(evict_valid), .evict_slot(evict_slot),
        .pred_valid(pred_valid), .pred_entry(pred_entry), .pred_addr(pred_addr),
        .pf_valid(pf_valid), .pf_addr(pf_addr), .pf_ready(pf_ready)
    );

    function automatic bit exp_pf();
        return pred_valid && m_mark[pred_entry];
    endfunction

    task automatic model_edge();
        bit       fire = evict_valid && m_occ[evict_slot];
        bit [4:0] own  = m_ptr[evict_slot];
        if (exp_pf() && pf_ready) m_mark[pred_entry] = 1'b0;
        if (fire) m_mark[own] = 1'b1;
        if (evict_valid) m_occ[evict_slot] = 1'b0;
        if (fill_valid) begin
            m_occ[fill_slot] = 1'b1;
            m_ptr[fill_slot] = fill_entry;
        end
    endtask

    // Inputs are already driven after a falling edge; check, then cross one rising edge.
    task automatic step(string tag);
        bit e;
        #1;
        e = exp_pf();
        checks++;
        if (pf_valid !== e) begin
            fails++;
            $display("FAIL %s pf_valid got %0b exp %0b", tag, pf_valid, e);
        end else if (e) begin
            checks++;
            if (pf_addr !== pred_addr) begin
                fails++;
                $display("FAIL %s pf_addr got %h exp %h", tag, pf_addr, pred_addr);
            end
        end
        @(posedge clk);
        model_edge();
        @(negedge clk);
        fill_valid = 0; evict_valid = 0; pred_valid = 0; pf_ready = 0;
    endtask

    task automatic do_fill(int s, int e);
        fill_valid = 1; fill_slot = 6'(s); fill_entry = 5'(e);
    endtask
    task automatic do_evict(int s);
        evict_valid = 1; evict_slot = 6'(s);
    endtask
    task automatic do_pred(int e, bit rdy);
        pred_valid = 1; pred_entry = 5'(e); pred_addr = $urandom; pf_ready = rdy;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NS; i++) begin m_occ[i] = 0; m_ptr[i] = 0; end
        for (int i = 0; i < NE; i++) m_mark[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: nothing marked after reset; evicting empty slots marks nothing
        for (int e = 0; e < NE; e++) begin do_pred(e, 1); step("R1"); end
        do_evict(0); step("R1");
        do_pred(0, 1); step("R1");

        // R2 R3 R4: fill slot 3 from entry 7, evict, predict
        do_fill(3, 7); step("R2");
        do_evict(3); step("R3");
        do_pred(7, 0); step("R4");
        // R5: refused request keeps mark, accepted one clears it
        do_pred(7, 0); step("R5");
        do_pred(7, 1); step("R5");
        do_pred(7, 1); step("R5");
        // R6: slot 3 is now empty, evicting again does nothing
        do_evict(3); step("R6");
        do_pred(7, 1); step("R6");

        // R7: same-cycle eviction and prediction of entry 9
        do_fill(5, 9); step("R7");
        do_evict(5); do_pred(9, 1); step("R7");
        do_pred(9, 0); step("R7");
        // R7: set wins over accepted clear
        do_fill(6, 9); step("R7");
        do_evict(6); do_pred(9, 1); step("R7");
        do_pred(9, 1); step("R7");
        do_pred(9, 1); step("R7");

        // R8: fill and evict slot 10 together
        do_fill(10, 2); step("R8");
        do_fill(10, 4); do_evict(10); step("R8");
        do_pred(2, 1); step("R8");
        do_pred(4, 1); step("R8");
        do_evict(10); step("R8");
        do_pred(4, 1); step("R8");

        // R9: seeded random mix over narrow ranges
        for (int n = 0; n < 4000; n++) begin
            if ($urandom % 3 == 0) do_fill($urandom % 12, $urandom % 6);
            if ($urandom % 3 == 0) do_evict($urandom % 12);
            if ($urandom % 2 == 0) do_pred($urandom % 6, 1'($urandom % 2));
            step("R9");
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule